// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets a host reach the management registers of external PHYs over a two-wire MDC/MDIO link using Clause 45 frames. The host sees four 32-bit registers on a simple write-strobe bus with combinational read data. Each frame-starting register access launches exactly one frame: storing a register offset sends an address frame, storing a value sends a write frame, and a control write with the read bit set sends a read frame whose returned word lands in the data register.

MDC is derived from the system clock by a programmable divider and stays low between frames. The block drives MDIO through an output-enable, so the pad can be released during the turnaround and data phase of a read. A flag in the status register tells the host when a read found no PHY answering, and two busy flags report bus activity and outstanding read/write operations.

Top module: `mdio45_master`

## Requirements
- R1: After reset the status register (word 0) reads 0x00003100 (divider field 0x31, both flags clear), control (word 1), data (word 2) and address (word 3) read zero, MDC is low and the MDIO output-enable is low.
- R2: With divider field F in status bits 15:8, MDC has a period of 2×(F+1) system clocks during a frame and is low whenever no frame is active.
- R3: MDIO changes only when MDC falls and is shifted most significant bit first; unless disabled, each frame begins with 32 ones, followed by start bits 00, a 2-bit opcode, the 5-bit port address, the 5-bit device address, a 2-bit turnaround and 16 data bits.
- R4: Writing word 3 while idle stores bits 15:0 and sends an address frame (opcode 00, turnaround 10) carrying that offset, port address control bits 9:5 and device address control bits 4:0.
- R5: Writing word 2 while idle stores bits 15:0 and sends a write frame (opcode 01, turnaround 10) carrying that value.
- R6: Writing word 1 with bit 15 set while idle sends a read frame with opcode 11, or 10 when bit 14 (post-increment) is set in that write; the output-enable drops from the first turnaround bit to the end of the frame, and the 16 bits sampled on MDC rising edges afterwards appear in data bits 15:0.
- R7: With control bit 10 set, the 32-bit preamble is skipped and the frame is 32 MDC cycles long.
- R8: Status bit 0 is high from the cycle after a frame starts until it ends, for every frame type; data bit 31 is high during read and write frames only.
- R9: Status bit 1 is set when MDIO is sampled high in the second turnaround bit of a read (the data then reads 0xFFFF when no PHY drives the line) and is cleared when the next frame starts.
- R10: While a frame is active, writes to word 2, word 3 and control writes with bit 15 set are ignored: no further frame starts and the stored data, address and control values are unchanged.
- R11: Control reads back port/device addresses, preamble-disable (bit 10), scan-enable (bit 11) and post-increment (bit 14) as written, with bit 15 always reading zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index (0 status, 1 control, 2 data, 3 address) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output-enable |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
The bench plays the PHY on the wire and reassembles every frame from the MDC rising edges, so address, write and read frames are compared bit by bit against frames rebuilt from the register fields. Reads are tried with a responding PHY returning random words and with an absent PHY leaving the line high, which separates correct sampling alignment and error detection from a shifted or missing capture. Random mixes of frame type, divider value, addresses and preamble setting separate divider and preamble-length faults from opcode or field-order faults, while writes issued mid-frame show whether the busy gating holds.

// File: rtl/mdio45_pkg.sv
`timescale 1ns/1ps
package mdio45_pkg;
  localparam int FRAME_LEN = 32;
  localparam int REG_W     = 16;
  localparam int ID_W      = 5;
  localparam int DIV_W     = 8;

  localparam logic [1:0] RIX_STAT = 2'd0;
  localparam logic [1:0] RIX_CTRL = 2'd1;
  localparam logic [1:0] RIX_DATA = 2'd2;
  localparam logic [1:0] RIX_ADDR = 2'd3;

  localparam int CB_PREDIS = 10;
  localparam int CB_SCAN   = 11;
  localparam int CB_PINC   = 14;
  localparam int CB_READ   = 15;

  typedef enum logic [1:0] {
    K_ADDR  = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2
  } frm_kind_e;

  function automatic logic [1:0] op_code(frm_kind_e k, logic pinc);
    case (k)
      K_ADDR:  return 2'b00;
      K_WRITE: return 2'b01;
      default: return pinc ? 2'b10 : 2'b11;
    endcase
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(frm_kind_e k, logic pinc,
      logic [ID_W-1:0] prt, logic [ID_W-1:0] dev, logic [REG_W-1:0] payload);
    logic [1:0] ta;
    ta = (k == K_READ) ? 2'b11 : 2'b10;
    return {2'b00, op_code(k, pinc), prt, dev, ta, payload};
  endfunction

  function automatic logic frame_bit(logic [FRAME_LEN-1:0] w, logic [4:0] idx);
    return w[5'd31 - idx];
  endfunction
endpackage

// File: rtl/mdio45_clkgen.sv
`timescale 1ns/1ps
module mdio45_clkgen import mdio45_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = run && (cnt == div);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio45_shifter.sv
`timescale 1ns/1ps
module mdio45_shifter import mdio45_pkg::*; #(
  parameter int PRE_LEN = 32,
  localparam int POS_W = $clog2(PRE_LEN + FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  frm_kind_e            start_kind,
  input  logic [FRAME_LEN-1:0] start_word,
  input  logic                 start_pre_dis,
  input  logic                 rise_evt,
  input  logic                 fall_evt,
  input  logic                 mdio_i,
  output logic                 active,
  output frm_kind_e            kind,
  output logic [POS_W-1:0]     pos,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic                 rd_err,
  output logic [REG_W-1:0]     rd_word
);
  localparam int LAST = PRE_LEN + FRAME_LEN - 1;
  localparam int TA1  = PRE_LEN + 14;
  localparam int TA2  = PRE_LEN + 15;

  logic [FRAME_LEN-1:0] word_q;
  logic                 at_last, in_read, released, in_pre;
  logic [4:0]           fidx;

  assign at_last  = (pos == POS_W'(LAST));
  assign in_read  = (kind == K_READ);
  assign released = in_read && (pos >= POS_W'(TA1));
  assign in_pre   = (pos < POS_W'(PRE_LEN));
  assign fidx     = 5'(pos - POS_W'(PRE_LEN));
  assign done     = active && fall_evt && at_last;
  assign mdio_o   = (active && !in_pre) ? frame_bit(word_q, fidx) : 1'b1;
  assign mdio_oe  = active && !released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      kind    <= K_ADDR;
      pos     <= '0;
      word_q  <= '0;
      rd_word <= '0;
      rd_err  <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      kind    <= start_kind;
      word_q  <= start_word;
      pos     <= start_pre_dis ? POS_W'(PRE_LEN) : '0;
      rd_word <= '0;
      rd_err  <= 1'b0;
    end else if (active) begin
      if (rise_evt && in_read) begin
        if (pos == POS_W'(TA2)) rd_err <= mdio_i;
        if (pos > POS_W'(TA2))  rd_word <= {rd_word[REG_W-2:0], mdio_i};
      end
      if (fall_evt) begin
        if (at_last) active <= 1'b0;
        else         pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio45_regs.sv
`timescale 1ns/1ps
module mdio45_regs import mdio45_pkg::*; #(
  parameter logic [DIV_W-1:0] DIV_RST = 8'd49
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 seq_busy,
  input  logic                 op_busy,
  input  logic                 rd_err,
  input  logic                 rd_done,
  input  logic [REG_W-1:0]     rd_word,
  output logic                 start,
  output frm_kind_e            start_kind,
  output logic [FRAME_LEN-1:0] start_word,
  output logic                 start_pre_dis,
  output logic [DIV_W-1:0]     div
);
  logic [ID_W-1:0]  dev_q, prt_q;
  logic             pd_q, scan_q, pinc_q;
  logic [REG_W-1:0] data_q, addr_q;
  logic             hit_stat, hit_ctrl, hit_data, hit_addr, rd_req;

  assign hit_stat = reg_wr && (reg_addr == RIX_STAT);
  assign hit_ctrl = reg_wr && (reg_addr == RIX_CTRL);
  assign hit_data = reg_wr && (reg_addr == RIX_DATA);
  assign hit_addr = reg_wr && (reg_addr == RIX_ADDR);
  assign rd_req   = hit_ctrl && reg_wdata[CB_READ];
  assign start    = !seq_busy && (hit_addr || hit_data || rd_req);

  always_comb begin
    start_kind = K_ADDR;
    if (hit_data)    start_kind = K_WRITE;
    else if (rd_req) start_kind = K_READ;
    start_pre_dis = rd_req ? reg_wdata[CB_PREDIS] : pd_q;
    if (rd_req)
      start_word = build_frame(K_READ, reg_wdata[CB_PINC], reg_wdata[9:5],
                               reg_wdata[4:0], '0);
    else
      start_word = build_frame(start_kind, pinc_q, prt_q, dev_q, reg_wdata[REG_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div    <= DIV_RST;
      dev_q  <= '0;
      prt_q  <= '0;
      pd_q   <= 1'b0;
      scan_q <= 1'b0;
      pinc_q <= 1'b0;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      if (hit_stat) div <= reg_wdata[15:8];
      if (hit_ctrl && !(rd_req && seq_busy)) begin
        dev_q  <= reg_wdata[4:0];
        prt_q  <= reg_wdata[9:5];
        pd_q   <= reg_wdata[CB_PREDIS];
        scan_q <= reg_wdata[CB_SCAN];
        pinc_q <= reg_wdata[CB_PINC];
      end
      if (hit_data && !seq_busy) data_q <= reg_wdata[REG_W-1:0];
      else if (rd_done)          data_q <= rd_word;
      if (hit_addr && !seq_busy) addr_q <= reg_wdata[REG_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      RIX_STAT: reg_rdata = {16'h0, div, 6'h0, rd_err, seq_busy};
      RIX_CTRL: reg_rdata = {16'h0, 1'b0, pinc_q, 2'b00, scan_q, pd_q, prt_q, dev_q};
      RIX_DATA: reg_rdata = {op_busy, 15'h0, data_q};
      default:  reg_rdata = {16'h0, addr_q};
    endcase
  end
endmodule

// File: rtl/mdio45_master.sv
`timescale 1ns/1ps
module mdio45_master import mdio45_pkg::*; #(
  parameter int               PRE_LEN = 32,
  parameter logic [DIV_W-1:0] DIV_RST = 8'd49
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int POS_W = $clog2(PRE_LEN + FRAME_LEN);

  logic                 seq_active, frm_start, frm_pre_dis, frm_done;
  logic                 ev_rise, ev_fall, rd_err_w, rd_done_w, op_busy_w;
  frm_kind_e            start_kind, frm_kind;
  logic [FRAME_LEN-1:0] start_word;
  logic [POS_W-1:0]     frm_pos;
  logic [REG_W-1:0]     rd_word;
  logic [DIV_W-1:0]     div;

  assign rd_done_w = frm_done && (frm_kind == K_READ);
  assign op_busy_w = seq_active && (frm_kind != K_ADDR);

  mdio45_regs #(.DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seq_busy(seq_active), .op_busy(op_busy_w), .rd_err(rd_err_w),
    .rd_done(rd_done_w), .rd_word(rd_word),
    .start(frm_start), .start_kind(start_kind), .start_word(start_word),
    .start_pre_dis(frm_pre_dis), .div(div)
  );

  mdio45_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(seq_active), .div(div),
    .mdc(mdc), .rise_evt(ev_rise), .fall_evt(ev_fall)
  );

  mdio45_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(frm_start), .start_kind(start_kind), .start_word(start_word),
    .start_pre_dis(frm_pre_dis), .rise_evt(ev_rise), .fall_evt(ev_fall),
    .mdio_i(mdio_i), .active(seq_active), .kind(frm_kind), .pos(frm_pos),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(frm_done),
    .rd_err(rd_err_w), .rd_word(rd_word)
  );
endmodule

// File: rtl/mdio45_master_chk.sv
`timescale 1ns/1ps
module mdio45_master_chk import mdio45_pkg::*; #(
  parameter int PRE_LEN = 32,
  localparam int POS_W = $clog2(PRE_LEN + FRAME_LEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             seq_active,
  input logic             frm_start,
  input frm_kind_e        frm_kind,
  input logic [POS_W-1:0] frm_pos,
  input logic             ev_fall,
  input logic             rd_err_w
);
  localparam int TA1 = PRE_LEN + 14;

  p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_active |-> !mdc);

  p_mdio_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && $past(seq_active) && !$past(ev_fall)) |-> $stable(mdio_o));

  p_preamble_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && (frm_pos < POS_W'(PRE_LEN))) |-> mdio_o);

  p_drive_addr_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && (frm_kind != K_READ)) |-> mdio_oe);

  p_release_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && (frm_kind == K_READ) && (frm_pos >= POS_W'(TA1))) |-> !mdio_oe);

  p_start_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> seq_active);

  p_err_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !rd_err_w);

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |-> !frm_start);
endmodule

bind mdio45_master mdio45_master_chk #(.PRE_LEN(PRE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .seq_active(seq_active), .frm_start(frm_start), .frm_kind(frm_kind),
  .frm_pos(frm_pos), .ev_fall(ev_fall), .rd_err_w(rd_err_w)
);

// File: tb/test_mdio45_master.sv
`timescale 1ns/1ps
module test_mdio45_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mdio45_master i_mdio45_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and frame monitor
  logic        mdc_prev = 1'b0;
  logic [63:0] mon_bits = '0;
  logic [63:0] mon_oe = '0;
  int          mon_n = 0;
  int          mon_off = 32;
  int          cyc = 0;
  int          rise0 = 0;
  int          rise1 = 0;
  logic        phy_here = 1'b0;
  logic [15:0] phy_resp = '0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (mdc && !mdc_prev) begin
      int j;
      mon_bits = {mon_bits[62:0], mdio_o};
      mon_oe   = {mon_oe[62:0], mdio_oe};
      if (mon_n == 0) rise0 = cyc;
      if (mon_n == 1) rise1 = cyc;
      mon_n++;
      j = mon_n - 1 - mon_off;
      if (!phy_here)               mdio_i = 1'b1;
      else if (j == 14)            mdio_i = 1'b0;
      else if (j >= 15 && j <= 30) mdio_i = phy_resp[30-j];
      else                         mdio_i = 1'b1;
    end
    mdc_prev = mdc;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(logic [1:0] op, logic [4:0] prt,
                                            logic [4:0] dev, logic [15:0] pl);
    logic [31:0] f;
    f = '0;
    f[29:28] = op;
    f[27:23] = prt;
    f[22:18] = dev;
    f[17:16] = 2'b10;
    f[15:0]  = pl;
    return f;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int g;
    g = 0;
    rd_reg(2'd0, s);
    while (s[0] && g < 20000) begin
      @(negedge clk);
      rd_reg(2'd0, s);
      g++;
    end
    if (s[0]) chk("R8 frame end", 1, 0);
  endtask

  task automatic arm(bit pd, bit here, logic [15:0] resp);
    mon_n = 0;
    mon_off = pd ? 0 : 32;
    phy_here = here;
    phy_resp = resp;
  endtask

  // kind: 0 address, 1 write, 2 read
  task automatic do_frame(int kind, logic [7:0] dv, logic [4:0] prt, logic [4:0] dev,
                          logic [15:0] pl, bit pd, bit pi, bit here, logic [15:0] resp);
    logic [31:0] r, ctl, ef;
    logic [1:0]  op;
    wr_reg(2'd0, {16'h0, dv, 8'h0});
    ctl = {16'h0, 1'b0, pi, 2'b00, 1'b0, pd, prt, dev};
    wr_reg(2'd1, ctl);
    arm(pd, here, resp);
    case (kind)
      0:       wr_reg(2'd3, {16'h0, pl});
      1:       wr_reg(2'd2, {16'h0, pl});
      default: wr_reg(2'd1, ctl | 32'h8000);
    endcase
    rd_reg(2'd0, r);
    chk("R8 bus busy after start", r[0], 1);
    chk("R9 error clear at start", r[1], 0);
    rd_reg(2'd2, r);
    chk("R8 op busy", r[31], (kind != 0));
    wait_idle();
    chk("R7/R3 frame length", mon_n, pd ? 32 : 64);
    if (!pd) chk("R3 preamble ones", mon_bits[63:32], 32'hFFFF_FFFF);
    chk("R2 mdc period", rise1 - rise0, 2 * (dv + 1));
    op = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (pi ? 2'b10 : 2'b11);
    ef = exp_frame(op, prt, dev, pl);
    if (kind == 2) begin
      chk("R6 read header", mon_bits[31:18], ef[31:18]);
      chk("R6 oe release", mon_oe[31:0], {14'h3FFF, 18'h0});
      rd_reg(2'd2, r);
      chk("R6/R9 read data", r, {16'h0, here ? resp : 16'hFFFF});
      rd_reg(2'd0, r);
      chk("R9 read error flag", r[1], !here);
      rd_reg(2'd1, r);
      chk("R11 read bit clear", r[15], 0);
    end else begin
      chk(kind == 0 ? "R4 address frame" : "R5 write frame", mon_bits[31:0], ef);
      chk("R5 oe driven", mon_oe[31:0], 32'hFFFF_FFFF);
      rd_reg(kind == 0 ? 2'd3 : 2'd2, r);
      chk(kind == 0 ? "R4 address readback" : "R5 data readback", r, {16'h0, pl});
    end
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, r); chk("R1 status reset", r, 32'h0000_3100);
    rd_reg(2'd1, r); chk("R1 control reset", r, 32'h0);
    rd_reg(2'd2, r); chk("R1 data reset", r, 32'h0);
    rd_reg(2'd3, r); chk("R1 address reset", r, 32'h0);
    chk("R1 mdc low", mdc, 0);
    chk("R1 oe low", mdio_oe, 0);

    // R11 control readback
    wr_reg(2'd1, 32'h0000_4DA5);
    rd_reg(2'd1, r); chk("R11 control readback", r, 32'h0000_4DA5);

    // Directed frames
    do_frame(0, 8'd1, 5'd3, 5'd1, 16'hA55A, 1'b0, 1'b0, 1'b1, 16'h0);
    do_frame(1, 8'd0, 5'd31, 5'd30, 16'h8001, 1'b1, 1'b0, 1'b1, 16'h0);
    do_frame(2, 8'd2, 5'd7, 5'd3, 16'h0, 1'b0, 1'b0, 1'b1, 16'hC3A5);
    do_frame(2, 8'd1, 5'd9, 5'd2, 16'h0, 1'b1, 1'b1, 1'b1, 16'h1234);
    do_frame(2, 8'd0, 5'd0, 5'd0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    rd_reg(2'd0, r); chk("R9 error held while idle", r[1], 1);
    do_frame(0, 8'd0, 5'd1, 5'd1, 16'h0001, 1'b1, 1'b0, 1'b1, 16'h0);

    // R10 writes during a frame are ignored
    wr_reg(2'd0, 32'h0000_0000);
    wr_reg(2'd1, 32'h0000_0062);
    arm(1'b0, 1'b1, 16'h0);
    wr_reg(2'd2, 32'h0000_BEEF);
    wr_reg(2'd2, 32'h0000_1111);
    wr_reg(2'd3, 32'h0000_2222);
    wr_reg(2'd1, 32'h0000_83FF);
    wait_idle();
    chk("R10 single frame", mon_n, 64);
    chk("R10 frame content", mon_bits[31:0], exp_frame(2'b01, 5'd3, 5'd2, 16'hBEEF));
    rd_reg(2'd2, r); chk("R10 data kept", r, 32'h0000_BEEF);
    rd_reg(2'd3, r); chk("R10 address kept", r, 32'h0000_0001);
    rd_reg(2'd1, r); chk("R10 control kept", r, 32'h0000_0062);
    repeat (10) @(negedge clk);
    rd_reg(2'd0, r); chk("R10 no extra frame", r[0], 0);

    // Random frames
    for (int i = 0; i < 10; i++) begin
      int          k;
      logic [7:0]  dv;
      logic [4:0]  prt, dev;
      logic [15:0] pl, rs;
      bit          pd, pi, here;
      k    = int'($urandom % 3);
      dv   = 8'($urandom % 4);
      prt  = 5'($urandom);
      dev  = 5'($urandom);
      pl   = 16'($urandom);
      rs   = 16'($urandom);
      pd   = 1'($urandom);
      pi   = 1'($urandom);
      here = ($urandom % 4) != 0;
      do_frame(k, dv, prt, dev, pl, pd, pi, here, rs);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule